// File: doc/BRIEF.md
# Calibration Pulse Shaper with Direction Flag

This block sits behind the energy accumulator of a metering datapath. Each time the accumulator crosses its threshold it raises a one-cycle strobe. The shaper turns that strobe into an active-high calibration pulse whose length depends on the selected mode and on how often strobes arrive. In the normal modes the pulse has a fixed long width of about 90 ms. When strobes come too often for that width, the pulse shrinks to half the measured strobe period. In the high-frequency mode the pulse is always a short fixed width of about 35 µs.

Next to the pulse, the block drives a reverse-power flag that follows the sign of the measured power. The flag is not a sticky latch: it takes a new value only when a calibration pulse begins, so an observer always sees the flag and the pulse change together. While the supply monitor reports that the supply is not ready, the block stays silent. Widths are given in cycles of the oscillator-rate clock. At 450 kHz the defaults give 40,500 cycles for the long width and 16 cycles for the short width.

Top module: `cal_pulse_shaper`

## Requirements
- R1: After reset, `cal_pulse_o` and `rev_power_o` are both low, and `cal_pulse_o` stays low until a strobe is accepted.
- R2: With `fast_mode_i` low, a pulse is LONG_W cycles wide when no valid period exists or when the measured period is 2*LONG_W cycles or more.
- R3: With `fast_mode_i` low and a measured period P below 2*LONG_W cycles, the pulse is floor(P/2) cycles wide, and never less than 1 cycle. P is the number of rising clock edges from one sampled strobe to the next.
- R4: With `fast_mode_i` high when the strobe is sampled, the pulse is SHORT_W cycles wide, whatever the period.
- R5: The first accepted strobe after reset, or after the supply was not ready, gives the fixed width of the current mode (LONG_W or SHORT_W).
- R6: `rev_power_o` takes the value of `neg_power_i` (1 = negative power) sampled with the accepted strobe. It changes in the same cycle that `cal_pulse_o` rises and holds its value at all other times.
- R7: A strobe that arrives while `cal_pulse_o` is high starts no pulse. It leaves the current width and `rev_power_o` unchanged, but it does restart the period measurement.
- R8: While `supply_ok_i` is low, `cal_pulse_o` is low in that same cycle, any running pulse is abandoned, strobes are ignored, `rev_power_o` holds its value, and the period history is cleared.
- R9: `cal_pulse_o` rises in the cycle after the edge that samples an accepted strobe and stays high for exactly the selected number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cal_strobe_i | input | 1 | One-cycle strobe from the accumulator threshold |
| neg_power_i | input | 1 | Power sign, 1 = negative |
| fast_mode_i | input | 1 | High-frequency mode selected |
| supply_ok_i | input | 1 | Supply monitor reports ready |
| cal_pulse_o | output | 1 | Calibration pulse, idles low |
| rev_power_o | output | 1 | Reverse-power flag, updated only when a pulse starts |

## Verification
The bound checker checks several rules on every clock. The flag never moves unless a pulse rises, and on a rise it carries the sign seen with the strobe. A strobe during a pulse leaves the flag alone. An idle, powered block answers a strobe in the next cycle. The output is quiet after a cycle with the supply down, and no pulse runs past LONG_W cycles. The exact width chosen for each case needs the bench's scenarios: half-period rounding, the boundary at 2*LONG_W, the period restart caused by a dropped strobe, the fixed width after reset or supply recovery, and the fast-mode override. The bench compares the block against its own cycle model on every clock.

// File: rtl/cps_pkg.sv
`timescale 1ns/1ps
// Shared types for the calibration pulse shaper.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package cps_pkg;

    // Which rule chose the width of the pulse about to start.
    typedef enum logic [1:0] {
        WSRC_FIXED = 2'd0,   // long fixed width, no usable period
        WSRC_HALF  = 2'd1,   // half of the measured period
        WSRC_FAST  = 2'd2    // short fixed width, high-frequency mode
    } wsrc_e;

endpackage

// File: rtl/cps_period_meter.sv
`timescale 1ns/1ps
// Measures the number of clock edges between successive sampled strobes.
// Saturates at SAT. The period is valid only when a previous strobe exists and
// the count has not saturated. History is cleared by reset and while
// enable_i (supply ready) is low.
// Assumes: strobes are one cycle wide and synchronous to clk.
module cps_period_meter #(
    parameter int unsigned SAT   = 80,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             strobe_i,
    output logic [CNT_W-1:0] period_o,
    output logic             valid_o
);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);

    logic [CNT_W-1:0] since_q;
    logic             have_q;

    // Count edges since the last strobe; restart on every strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            since_q <= '0;
            have_q  <= 1'b0;
        end else if (strobe_i) begin
            since_q <= CNT_W'(1);
            have_q  <= 1'b1;
        end else if (since_q < SAT_V) begin
            since_q <= since_q + 1'b1;
        end
    end

    assign period_o = since_q;
    assign valid_o  = have_q && (since_q < SAT_V);

endmodule

// File: rtl/cps_width_select.sv
`timescale 1ns/1ps
// Picks the width of the next pulse from the mode and the measured period.
// Fast mode wins. Otherwise a valid period gives half of it (at least 1);
// with no valid period the long fixed width is used.
// Assumes: LONG_W and SHORT_W fit in CNT_W bits and are nonzero.
module cps_width_select
    import cps_pkg::*;
#(
    parameter int unsigned LONG_W  = 40,
    parameter int unsigned SHORT_W = 4,
    parameter int unsigned CNT_W   = 8
) (
    input  logic             fast_i,
    input  logic             valid_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] width_o
);
    localparam logic [CNT_W-1:0] LONG_V  = CNT_W'(LONG_W);
    localparam logic [CNT_W-1:0] SHORT_V = CNT_W'(SHORT_W);

    wsrc_e            src;
    logic [CNT_W-1:0] half;

    // Decide which rule applies.
    always_comb begin
        if (fast_i)       src = WSRC_FAST;
        else if (valid_i) src = WSRC_HALF;
        else              src = WSRC_FIXED;
    end

    // Half period, floored, with a one-cycle minimum.
    always_comb begin
        half = period_i >> 1;
        if (half == '0) half = CNT_W'(1);
    end

    // Width mux driven by the chosen rule.
    always_comb begin
        unique case (src)
            WSRC_FAST: width_o = SHORT_V;
            WSRC_HALF: width_o = half;
            default:   width_o = LONG_V;
        endcase
    end

endmodule

// File: rtl/cps_pulse_timer.sv
`timescale 1ns/1ps
// Holds the pulse high for a loaded number of cycles.
// The output is gated by enable_i so that it drops in the same cycle the
// supply goes away; the count is also cleared at the next edge.
// Assumes: start_i is only raised when busy_o is low.
module cps_pulse_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] width_i,
    output logic             busy_o,
    output logic             pulse_o
);
    logic [CNT_W-1:0] rem_q;

    // Load on start, count down to zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i) begin
            rem_q <= '0;
        end else if (start_i) begin
            rem_q <= width_i;
        end else if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
        end
    end

    assign busy_o  = (rem_q != '0);
    assign pulse_o = busy_o && enable_i;

endmodule

// File: rtl/cps_dir_flag.sv
`timescale 1ns/1ps
// Reverse-power flag: captures the power sign only when a pulse starts.
// Assumes: load_i is high for exactly the cycle in which a pulse is accepted.
module cps_dir_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic neg_i,
    output logic rev_o
);
    // Capture the sign together with the pulse start.
    always_ff @(posedge clk) begin
        if (!rst_n)      rev_o <= 1'b0;
        else if (load_i) rev_o <= neg_i;
    end

endmodule

// File: rtl/cal_pulse_shaper.sv
`timescale 1ns/1ps
// Calibration pulse shaper with reverse-power flag.
// Turns each accepted strobe into a pulse of mode- and period-dependent width.
// The direction flag is updated in step with each pulse.
// Assumes: all inputs are synchronous to clk; strobes are one cycle wide.
module cal_pulse_shaper #(
    parameter int unsigned LONG_W  = 40500,
    parameter int unsigned SHORT_W = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cal_strobe_i,
    input  logic neg_power_i,
    input  logic fast_mode_i,
    input  logic supply_ok_i,
    output logic cal_pulse_o,
    output logic rev_power_o
);
    localparam int unsigned PER_MAX = 2 * LONG_W;
    localparam int unsigned CNT_W   = $clog2(PER_MAX + 1);

    logic [CNT_W-1:0] period;
    logic             period_ok;
    logic [CNT_W-1:0] width;
    logic             busy;
    logic             accept;

    // A strobe starts a pulse only when powered and idle.
    assign accept = cal_strobe_i && supply_ok_i && !busy;

    cps_period_meter #(.SAT(PER_MAX), .CNT_W(CNT_W)) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (supply_ok_i),
        .strobe_i (cal_strobe_i),
        .period_o (period),
        .valid_o  (period_ok)
    );

    cps_width_select #(.LONG_W(LONG_W), .SHORT_W(SHORT_W), .CNT_W(CNT_W)) u_sel (
        .fast_i   (fast_mode_i),
        .valid_i  (period_ok),
        .period_i (period),
        .width_o  (width)
    );

    cps_pulse_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable_i (supply_ok_i),
        .start_i  (accept),
        .width_i  (width),
        .busy_o   (busy),
        .pulse_o  (cal_pulse_o)
    );

    cps_dir_flag u_dir (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .neg_i  (neg_power_i),
        .rev_o  (rev_power_o)
    );

endmodule

// File: rtl/cal_pulse_shaper_checker.sv
`timescale 1ns/1ps
// Temporal checks for cal_pulse_shaper, attached with bind below.
// Assumes: the same LONG_W as the bound instance.
module cal_pulse_shaper_checker #(
    parameter int unsigned LONG_W = 40500
) (
    input logic clk,
    input logic rst_n,
    input logic cal_strobe_i,
    input logic neg_power_i,
    input logic supply_ok_i,
    input logic cal_pulse_o,
    input logic rev_power_o
);
    localparam int unsigned RW  = $clog2(LONG_W + 2);
    localparam logic [RW-1:0] LIM = RW'(LONG_W);

    logic [RW-1:0] run_q;

    // Count the high cycles of the current pulse seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n)                            run_q <= '0;
        else if (cal_pulse_o && run_q != '1)   run_q <= run_q + 1'b1;
        else if (!cal_pulse_o)                 run_q <= '0;
    end

    AST_WIDTH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cal_pulse_o |-> (run_q < LIM));                                        // R2
    AST_DIR_MOVES_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rev_power_o) |-> $rose(cal_pulse_o));                         // R6
    AST_DIR_SAMPLES_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_pulse_o) |-> (rev_power_o == $past(neg_power_i)));           // R6
    AST_BUSY_STROBE_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_strobe_i && cal_pulse_o) |=> $stable(rev_power_o));               // R7
    AST_SUPPLY_DOWN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok_i |=> !cal_pulse_o);                                        // R8
    AST_STROBE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_strobe_i && supply_ok_i && !cal_pulse_o) |=> (cal_pulse_o || !supply_ok_i)); // R9

endmodule

bind cal_pulse_shaper cal_pulse_shaper_checker #(.LONG_W(LONG_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_strobe_i (cal_strobe_i),
    .neg_power_i  (neg_power_i),
    .supply_ok_i  (supply_ok_i),
    .cal_pulse_o  (cal_pulse_o),
    .rev_power_o  (rev_power_o)
);

// File: tb/cal_pulse_shaper_bench.sv
`timescale 1ns/1ps
module cal_pulse_shaper_bench;
    localparam int LW = 40;
    localparam int SW = 4;

    logic clk = 1'b0, rst_n = 1'b0, strobe = 1'b0, neg = 1'b0, fast = 1'b0, sup = 1'b0;
    wire  cal, rev;

    always #2.5 clk = ~clk;

    cal_pulse_shaper #(.LONG_W(LW), .SHORT_W(SW)) u_cal_pulse_shaper (
        .clk(clk), .rst_n(rst_n), .cal_strobe_i(strobe), .neg_power_i(neg),
        .fast_mode_i(fast), .supply_ok_i(sup), .cal_pulse_o(cal), .rev_power_o(rev));

    int errors = 0, checks = 0;
    bit finished = 0;

    // Behavioural model: edge numbers, pulse end edge, last strobe edge.
    int cyc = 0, m_end = 0, m_last = -1000, m_rev = 0, w = 0;
    bit m_have = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            cyc = 0; m_end = 0; m_last = -1000; m_rev = 0; m_have = 0;
        end else begin
            cyc++;
            if (!sup) begin
                m_end = 0; m_have = 0;
            end else if (strobe) begin
                if (m_end < cyc) begin
                    if (fast) w = SW;
                    else if (m_have && (cyc - m_last) < 2*LW) w = ((cyc - m_last) / 2 > 0) ? (cyc - m_last) / 2 : 1;
                    else w = LW;
                    m_end = cyc + w;
                    m_rev = neg;
                end
                m_have = 1; m_last = cyc;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model (R9 timing/width, R6 flag).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R9 cycle model cal", int'(cal), int'(sup && (cyc < m_end)));
            chk("R6 cycle model rev", int'(rev), m_rev);
        end
    end

    // Width monitor: records the length of the last finished pulse.
    int run = 0, last_w = 0;
    always @(posedge clk) begin
        if (cal) run++;
        else if (run > 0) begin last_w = run; run = 0; end
    end

    task automatic strobe_now(input bit n);
        @(negedge clk); strobe = 1'b1; neg = n;
        @(negedge clk); strobe = 1'b0;
    endtask

    task automatic fire_at(input int p, input bit n);
        while (cyc != m_last + p - 1) @(negedge clk);
        strobe = 1'b1; neg = n;
        @(negedge clk); strobe = 1'b0;
    endtask

    task automatic wait_done();
        while (cal) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 reset cal", int'(cal), 0);
        chk("R1 reset rev", int'(rev), 0);
        rst_n = 1'b1; sup = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle cal", int'(cal), 0);

        strobe_now(1'b1);
        chk("R9 rise after strobe", int'(cal), 1);
        chk("R6 rev with pulse", int'(rev), 1);
        wait_done(); chk("R5 first width", last_w, LW);

        fire_at(100, 1'b0); chk("R6 rev cleared", int'(rev), 0);
        wait_done(); chk("R2 long period width", last_w, LW);
        fire_at(60, 1'b0);  wait_done(); chk("R3 half of 60", last_w, 30);
        fire_at(40, 1'b1);  wait_done(); chk("R3 half of 40", last_w, 20);
        neg = 1'b0; repeat (5) @(negedge clk);
        chk("R6 rev holds between pulses", int'(rev), 1);
        fire_at(30, 1'b1);  wait_done(); chk("R3 half of 30", last_w, 15);
        fire_at(79, 1'b0);  wait_done(); chk("R3 half of 79", last_w, 39);
        fire_at(80, 1'b0);  wait_done(); chk("R2 period at limit", last_w, LW);
        fire_at(81, 1'b0);  wait_done(); chk("R2 period above limit", last_w, LW);

        fire_at(100, 1'b1);
        fire_at(10, 1'b0);
        chk("R7 busy strobe keeps rev", int'(rev), 1);
        chk("R7 busy strobe keeps pulse", int'(cal), 1);
        wait_done(); chk("R7 width unchanged", last_w, LW);
        fire_at(50, 1'b0);  wait_done(); chk("R7 period restarted", last_w, 25);

        fast = 1'b1;
        fire_at(100, 1'b1); wait_done(); chk("R4 fast long period", last_w, SW);
        fire_at(30, 1'b0);  wait_done(); chk("R4 fast short period", last_w, SW);
        fire_at(10, 1'b1);  wait_done(); chk("R4 fast tight period", last_w, SW);
        fast = 1'b0;

        fire_at(100, 1'b0);
        repeat (10) @(negedge clk);
        sup = 1'b0; #1;
        chk("R8 cal drops with supply", int'(cal), 0);
        strobe_now(1'b1);
        chk("R8 strobe ignored cal", int'(cal), 0);
        chk("R8 strobe ignored rev", int'(rev), 0);
        repeat (3) @(negedge clk);
        sup = 1'b1;
        repeat (3) @(negedge clk);
        chk("R8 no pulse on recovery", int'(cal), 0);
        strobe_now(1'b1);
        chk("R6 rev after recovery", int'(rev), 1);
        wait_done(); chk("R5 fixed width after recovery", last_w, LW);
        fire_at(60, 1'b0);  wait_done(); chk("R3 period after recovery", last_w, 30);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule